// File: doc/BRIEF.md
# Big-Endian Byte-Addressed Data Memory

A synchronous memory for a 32-bit load/store core. Every address selects one 8-bit byte, and a single read/write port performs byte, half-word and word accesses. Within a word the byte at the lowest address is the most significant. Loads come back right-justified in a 32-bit result, sign- or zero-extended on request. Stores of one or two bytes merge into the containing word and leave the other lanes untouched.

Accesses must be naturally aligned. A misaligned load or store raises an error flag in the same cycle and returns zero. A misaligned store writes nothing. A second, read-only port fetches aligned 32-bit instruction words from the same storage and flags misaligned fetch addresses. Writes commit on the rising clock edge. Reads are combinational, so a location written in one cycle reads back with its new value in the next.

Top module: `be_data_mem`

## Requirements
- R1: `size_i` encodes the access width: 00 is byte, 01 is half-word, 10 or 11 is word. A word load at byte address A returns bytes A, A+1, A+2, A+3 in bits 31:24, 23:16, 15:8 and 7:0. Storing word 0xAA1513FF at address 0 and loading it back returns 0xAA1513FF.
- R2: A half-word load at offset 0 returns bytes 0 and 1 of the word. A load at offset 2 returns bytes 2 and 3. The lower-addressed byte goes in bits 15:8. With word 0xAA1513FF these loads give 0xAA15 and 0x13FF.
- R3: A byte load at offset k (0 to 3) returns the byte stored at that address in bits 7:0. Offset 0 is the word's bits 31:24.
- R4: A byte store changes only its own byte, using `wdata_i[7:0]`. A half-word store changes only its two bytes, using `wdata_i[15:0]`. All other bytes of the word keep their values.
- R5: A half-word access with address bit 0 set, or a word access with address bits 1:0 not both zero, sets `err_o` in that cycle and drives `rdata_o` to zero. Byte accesses are never misaligned.
- R6: A misaligned store changes no memory byte.
- R7: Byte and half-word loads place the value in the low bits. With `sext_i` high the upper bits copy the value's top bit. With `sext_i` low they are zero.
- R8: A store commits on the rising clock edge and is not visible before it. A load is combinational from the current address, so a load in the next cycle returns the new data.
- R9: `instr_o` returns the big-endian word at `iaddr_i`. If `iaddr_i[1:0]` is nonzero, `ierr_o` is set and `instr_o` is zero.
- R10: Address bits above the storage range (bit WORD_AW+2 and higher) are ignored on both ports, so addresses that differ only there reach the same byte.
- R11: While `rst_ni` is low, every byte is cleared to zero and stores have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; stores commit on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset; clears storage |
| addr_i | input | ADDR_W | Byte address of the data access |
| size_i | input | 2 | Access width: 00 byte, 01 half, 1x word |
| we_i | input | 1 | Store enable |
| sext_i | input | 1 | Sign-extend sub-word loads when high |
| wdata_i | input | 32 | Store data, right-justified |
| rdata_o | output | 32 | Load data, right-justified and extended |
| err_o | output | 1 | Misaligned data access |
| iaddr_i | input | ADDR_W | Byte address of the instruction fetch |
| instr_o | output | 32 | Fetched instruction word |
| ierr_o | output | 1 | Misaligned instruction fetch |

## Verification
The load path is exercised on one known word at every byte offset and at both half-word offsets, with both extension settings. One value has its top bit set and one has it clear, so a lane swap can be told apart from an extension fault. Stores of each width are placed over existing data, which exposes lane masks that are too wide and bytes that are reversed. Every misaligned half-word and word offset is tried as both a load and a store, and the surrounding word is read back afterwards. Addresses that differ only in bits above the storage range show whether those bits are really ignored. A byte-array model then replays stores and loads across a whole region on both ports.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } acc_size_e;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
endpackage

// File: rtl/be_align_chk.sv
module be_align_chk
  import be_mem_pkg::*;
(
  input  acc_size_e  size_i,
  input  logic [1:0] off_i,
  output logic       misal_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: misal_o = 1'b0;
      SZ_HALF: misal_o = off_i[0];
      default: misal_o = |off_i;
    endcase
  end
endmodule

// File: rtl/be_store_lanes.sv
module be_store_lanes
  import be_mem_pkg::*;
(
  input  acc_size_e          size_i,
  input  logic [1:0]         off_i,
  input  logic               en_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [LANES-1:0]   be_o,
  output logic [WORD_W-1:0]  data_o
);
  // lane g holds bits [8g+7:8g]; byte offset k lives in lane 3-k
  logic [LANES-1:0] mask;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        mask   = 4'b1000 >> off_i;
        data_o = {LANES{wdata_i[LANE_W-1:0]}};
      end
      SZ_HALF: begin
        mask   = off_i[1] ? 4'b0011 : 4'b1100;
        data_o = {2{wdata_i[2*LANE_W-1:0]}};
      end
      default: begin
        mask   = '1;
        data_o = wdata_i;
      end
    endcase
    be_o = en_i ? mask : '0;
  end
endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
  import be_mem_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  acc_size_e         size_i,
  input  logic [1:0]        off_i,
  input  logic              sext_i,
  input  logic              misal_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [LANE_W-1:0]   byte_v;
  logic [2*LANE_W-1:0] half_v;

  // offset k selects bits starting at 8*(3-k), i.e. {~k,3'b0}
  assign byte_v = word_i[{~off_i, 3'b000} +: LANE_W];
  assign half_v = off_i[1] ? word_i[2*LANE_W-1:0] : word_i[WORD_W-1:2*LANE_W];

  always_comb begin
    if (misal_i) begin
      rdata_o = '0;
    end else begin
      unique case (size_i)
        SZ_BYTE: rdata_o = {{(WORD_W-LANE_W){sext_i & byte_v[LANE_W-1]}}, byte_v};
        SZ_HALF: rdata_o = {{(WORD_W-2*LANE_W){sext_i & half_v[2*LANE_W-1]}}, half_v};
        default: rdata_o = word_i;
      endcase
    end
  end
endmodule

// File: rtl/be_data_mem.sv
module be_data_mem
  import be_mem_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORD_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  input  logic              sext_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  input  logic [ADDR_W-1:0] iaddr_i,
  output logic [31:0]       instr_o,
  output logic              ierr_o
);
  localparam int unsigned DEPTH = 1 << WORD_AW;
  localparam int unsigned IDX_HI = WORD_AW + 1;

  acc_size_e           dsize;
  logic [WORD_AW-1:0]  didx, iidx;
  logic [LANES-1:0]    be;
  logic [WORD_W-1:0]   lane_data, dword, iword;
  logic                dmisal, imisal;
  logic                unused_hi;

  assign dsize = acc_size_e'(size_i);
  assign didx  = addr_i[IDX_HI:2];
  assign iidx  = iaddr_i[IDX_HI:2];
  assign unused_hi = ^{addr_i[ADDR_W-1:IDX_HI+1], iaddr_i[ADDR_W-1:IDX_HI+1]};

  be_align_chk u_dchk (.size_i(dsize),   .off_i(addr_i[1:0]),  .misal_o(dmisal));
  be_align_chk u_ichk (.size_i(SZ_WORD), .off_i(iaddr_i[1:0]), .misal_o(imisal));

  be_store_lanes u_st (
    .size_i (dsize),
    .off_i  (addr_i[1:0]),
    .en_i   (we_i & ~dmisal),
    .wdata_i(wdata_i),
    .be_o   (be),
    .data_o (lane_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
      end else if (be[g]) begin
        lane_q[didx] <= lane_data[g*LANE_W +: LANE_W];
      end
    end

    assign dword[g*LANE_W +: LANE_W] = lane_q[didx];
    assign iword[g*LANE_W +: LANE_W] = lane_q[iidx];
  end

  be_load_extract u_ld (
    .word_i (dword),
    .size_i (dsize),
    .off_i  (addr_i[1:0]),
    .sext_i (sext_i),
    .misal_i(dmisal),
    .rdata_o(rdata_o)
  );

  assign err_o   = dmisal;
  assign ierr_o  = imisal;
  assign instr_o = imisal ? '0 : iword;

  a_r5_half_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b01 && addr_i[0]) |-> (err_o && rdata_o == '0));
  a_r5_word_unal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i[1] && addr_i[1:0] != 2'b00) |-> (err_o && rdata_o == '0));
  a_r4_byte_lane: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b00) |-> ($countones(be) <= 1));
  a_r6_misal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && err_o) |=> (didx != $past(didx) || dword == $past(dword)));
  a_r7_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b00 && !sext_i) |-> (rdata_o[31:8] == '0));
  a_r7_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b00 && sext_i) |-> (rdata_o[31:8] == {24{rdata_o[7]}}));
  a_r8_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !err_o && size_i[1]) |=>
      (addr_i != $past(addr_i) || !size_i[1] || rdata_o == $past(wdata_i)));
  a_r9_fetch_unal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iaddr_i[1:0] != 2'b00) |-> (ierr_o && instr_o == '0));
endmodule

// File: tb/be_data_mem_tb_top.sv
`timescale 1ns/1ps
module be_data_mem_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [31:0] addr = '0, iaddr = '0, wdata = '0;
  logic [1:0]  size = '0;
  logic        we = 1'b0, sext = 1'b0;
  logic [31:0] rdata, instr;
  logic        err, ierr;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;
  logic [7:0]  ref_mem [256];

  always #4 clk = ~clk;

  be_data_mem dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .size_i(size), .we_i(we),
    .sext_i(sext), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .iaddr_i(iaddr), .instr_o(instr), .ierr_o(ierr)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic        sx;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd2, 1'b0, 32'h0,        32'hAA1513FF, 32'h0,        1'b0, 4'd8},  // R8
    '{1'b0, 2'd2, 1'b0, 32'h0,        32'h0,        32'hAA1513FF, 1'b0, 4'd1},  // R1
    '{1'b0, 2'd1, 1'b0, 32'h0,        32'h0,        32'h0000AA15, 1'b0, 4'd2},  // R2
    '{1'b0, 2'd1, 1'b1, 32'h0,        32'h0,        32'hFFFFAA15, 1'b0, 4'd7},  // R7
    '{1'b0, 2'd1, 1'b0, 32'h2,        32'h0,        32'h000013FF, 1'b0, 4'd2},  // R2
    '{1'b0, 2'd1, 1'b1, 32'h2,        32'h0,        32'h000013FF, 1'b0, 4'd7},  // R7
    '{1'b0, 2'd0, 1'b1, 32'h0,        32'h0,        32'hFFFFFFAA, 1'b0, 4'd3},  // R3
    '{1'b0, 2'd0, 1'b0, 32'h0,        32'h0,        32'h000000AA, 1'b0, 4'd7},  // R7
    '{1'b0, 2'd0, 1'b1, 32'h1,        32'h0,        32'h00000015, 1'b0, 4'd3},  // R3
    '{1'b0, 2'd0, 1'b0, 32'h2,        32'h0,        32'h00000013, 1'b0, 4'd3},  // R3
    '{1'b0, 2'd0, 1'b1, 32'h3,        32'h0,        32'hFFFFFFFF, 1'b0, 4'd7},  // R7
    '{1'b0, 2'd0, 1'b0, 32'h3,        32'h0,        32'h000000FF, 1'b0, 4'd3},  // R3
    '{1'b1, 2'd0, 1'b0, 32'h1,        32'h0000007E, 32'h00000015, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd2, 1'b0, 32'h0,        32'h0,        32'hAA7E13FF, 1'b0, 4'd4},  // R4
    '{1'b1, 2'd1, 1'b0, 32'h2,        32'h12348001, 32'h000013FF, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd2, 1'b0, 32'h0,        32'h0,        32'hAA7E8001, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd1, 1'b1, 32'h2,        32'h0,        32'hFFFF8001, 1'b0, 4'd7},  // R7
    '{1'b1, 2'd2, 1'b0, 32'h2,        32'h11111111, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b0, 2'd2, 1'b0, 32'h0,        32'h0,        32'hAA7E8001, 1'b0, 4'd6},  // R6
    '{1'b1, 2'd1, 1'b0, 32'h1,        32'h0000FFFF, 32'h0,        1'b1, 4'd6},  // R6
    '{1'b0, 2'd2, 1'b0, 32'h0,        32'h0,        32'hAA7E8001, 1'b0, 4'd6},  // R6
    '{1'b0, 2'd1, 1'b0, 32'h3,        32'h0,        32'h0,        1'b1, 4'd5},  // R5
    '{1'b0, 2'd2, 1'b0, 32'h1,        32'h0,        32'h0,        1'b1, 4'd5},  // R5
    '{1'b0, 2'd2, 1'b0, 32'h3,        32'h0,        32'h0,        1'b1, 4'd5},  // R5
    '{1'b1, 2'd0, 1'b0, 32'h3,        32'h0000005A, 32'h00000001, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd2, 1'b0, 32'h0,        32'h0,        32'hAA7E805A, 1'b0, 4'd4},  // R4
    '{1'b0, 2'd3, 1'b0, 32'h4,        32'h0,        32'h0,        1'b0, 4'd1},  // R1
    '{1'b1, 2'd3, 1'b0, 32'h4,        32'h01020304, 32'h0,        1'b0, 4'd1},  // R1
    '{1'b0, 2'd2, 1'b0, 32'h4,        32'h0,        32'h01020304, 1'b0, 4'd8},  // R8
    '{1'b0, 2'd0, 1'b0, 32'h100,      32'h0,        32'h000000AA, 1'b0, 4'd10}, // R10
    '{1'b1, 2'd0, 1'b0, 32'h10000101, 32'h00000033, 32'h0000007E, 1'b0, 4'd10}, // R10
    '{1'b0, 2'd2, 1'b0, 32'h0,        32'h0,        32'hAA33805A, 1'b0, 4'd10}  // R10
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] sz, input logic sx,
                       input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    we = w; size = sz; sext = sx; addr = a; wdata = d;
    #1;
  endtask

  function automatic logic aligned(input logic [1:0] sz, input logic [7:0] a);
    return (sz == 2'd0) || (sz == 2'd1 && !a[0]) || (sz[1] && a[1:0] == 2'b00);
  endfunction

  task automatic model_store(input logic [1:0] sz, input logic [31:0] a32,
                             input logic [31:0] d);
    logic [7:0] a;
    a = a32[7:0];
    if (!aligned(sz, a)) return;
    if (sz == 2'd0) ref_mem[a] = d[7:0];
    else if (sz == 2'd1) begin
      ref_mem[a] = d[15:8]; ref_mem[a+8'd1] = d[7:0];
    end else begin
      ref_mem[a] = d[31:24]; ref_mem[a+8'd1] = d[23:16];
      ref_mem[a+8'd2] = d[15:8]; ref_mem[a+8'd3] = d[7:0];
    end
  endtask

  function automatic logic [32:0] model_load(input logic [1:0] sz, input logic sx,
                                             input logic [31:0] a32);
    logic [7:0] a;
    logic [15:0] h;
    a = a32[7:0];
    if (!aligned(sz, a)) return {1'b1, 32'h0};
    if (sz == 2'd0) return {1'b0, {24{sx & ref_mem[a][7]}}, ref_mem[a]};
    h = {ref_mem[a], ref_mem[a+8'd1]};
    if (sz == 2'd1) return {1'b0, {16{sx & h[15]}}, h};
    return {1'b0, h, ref_mem[a+8'd2], ref_mem[a+8'd3]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [32:0] m;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    #1;
    chk(11, rdata, 32'h0, "reset word 0");       // R11
    chk(11, {31'h0, err}, 32'h0, "reset err");   // R11

    // table walk
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].we, VECS[v].sz, VECS[v].sx, VECS[v].addr, VECS[v].wd);
      chk(VECS[v].rq, rdata, VECS[v].exp, $sformatf("vec %0d rdata", v));
      chk(VECS[v].rq, {31'h0, err}, {31'h0, VECS[v].err}, $sformatf("vec %0d err", v));
      if (VECS[v].we) model_store(VECS[v].sz, VECS[v].addr, VECS[v].wd);
    end

    // fetch port, R9 and R10
    drive(1'b0, 2'd2, 1'b0, 32'h0, 32'h0);
    iaddr = 32'h0; #1;
    chk(9, instr, 32'hAA33805A, "fetch 0");
    chk(9, {31'h0, ierr}, 32'h0, "fetch 0 err");
    iaddr = 32'h4; #1;
    chk(9, instr, 32'h01020304, "fetch 4");
    iaddr = 32'h00000104; #1;
    chk(10, instr, 32'h01020304, "fetch alias");
    for (int o = 1; o < 4; o++) begin
      iaddr = 32'h4 + 32'(o); #1;
      chk(9, {31'h0, ierr}, 32'h1, $sformatf("fetch off %0d err", o));
      chk(9, instr, 32'h0, $sformatf("fetch off %0d data", o));
    end
    iaddr = 32'h0;

    // model sweep: byte stores at every offset, then all loads (R3 R5 R7)
    for (int k = 0; k < 16; k++) begin
      drive(1'b1, 2'd0, 1'b0, 32'h40 + 32'(k), 32'((k * 37 + 133) & 255));
      model_store(2'd0, 32'h40 + 32'(k), 32'((k * 37 + 133) & 255));
    end
    drive(1'b1, 2'd1, 1'b0, 32'h46, 32'h0000C3A5);   // R4 half at offset 2
    model_store(2'd1, 32'h46, 32'h0000C3A5);
    for (int k = 0; k < 16; k++) begin
      for (int s = 0; s < 3; s++) begin
        for (int x = 0; x < 2; x++) begin
          drive(1'b0, 2'(s), 1'(x), 32'h40 + 32'(k), 32'h0);
          m = model_load(2'(s), 1'(x), 32'h40 + 32'(k));
          chk(7, rdata, m[31:0], $sformatf("sweep a=%0h s=%0d x=%0d", 8'h40 + k, s, x));
          chk(5, {31'h0, err}, {31'h0, m[32]}, $sformatf("sweep err a=%0h s=%0d", 8'h40 + k, s));
        end
      end
      iaddr = 32'h40 + 32'(k); #1;
      m = model_load(2'd2, 1'b0, 32'h40 + 32'(k));
      chk(9, instr, m[31:0], $sformatf("sweep fetch a=%0h", 8'h40 + k));
    end
    iaddr = 32'h0;

    // reset clears and blocks stores, R11
    @(negedge clk);
    rst_ni = 1'b0; we = 1'b1; size = 2'd2; addr = 32'h0; wdata = 32'hDEADBEEF;
    @(negedge clk); #1;
    chk(11, rdata, 32'h0, "word 0 in reset");
    @(negedge clk);
    rst_ni = 1'b1; we = 1'b0;
    #1;
    chk(11, rdata, 32'h0, "word 0 after reset");
    addr = 32'h44; #1;
    chk(11, rdata, 32'h0, "word 0x44 after reset");
    iaddr = 32'h4; #1;
    chk(11, instr, 32'h0, "fetch 4 after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule